// File: doc/BRIEF.md
# Power-Management Event Status and Enable Registers

This block holds the power-management event state of a platform: a 16-bit status word that records events (power button, sleep button, real-time clock alarm, timer overflow, global lock release, bus-master activity, wake) and a 16-bit enable word that selects which of those events may interrupt the processor. From these two words it derives the level-sensitive system control interrupt (SCI), which stays high as long as any enabled event remains latched.

Software reaches the two words through a pair of word-wide I/O locations: the status word at the base address and the enable word two bytes above it. Only two-byte accesses are accepted. Status bits are cleared by writing ones. Event inputs are single-cycle or held pulses from the event sources, and the SCI output is wired to the interrupt router.

Top module: `pm1_evt_regs`

## Requirements
- R1: After reset the status word and the enable word both read 0x0000 and `sci` is low.
- R2: An access to either word with `acc_size` other than 2 bytes raises `acc_err` in that cycle, returns 0 on `acc_rdata` and changes neither word.
- R3: A two-byte read at `BASE_ADDR` returns the status word and one at `BASE_ADDR`+2 returns the enable word; any other address returns 0 with `acc_err` low.
- R4: Each event input sets its own status bit on the next clock edge: timer bit 0, bus master bit 4, global bit 5, power button bit 8, sleep button bit 9, RTC bit 10, wake bit 15.
- R5: A status write clears exactly the bits written as 1 among bits 15, 10, 9, 8 and 4; bits 0 and 5 and all other bits ignore the write.
- R6: An enable write keeps only bit 8 (power button) and bit 5 (global); every other enable bit reads 0.
- R7: `sci` is high exactly when, for at least one of bits 0, 5, 8, 9, 10, both the enable bit and the status bit are set; it follows each event or write on the same clock edge that updates the words.
- R8: An event arriving in the same cycle as a write-1-to-clear of its own status bit wins, so the bit stays set.
- R9: A power-button event while the power-button status bit is already set leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | I/O address of the access |
| acc_size | input | 3 | Access width in bytes |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid in the access cycle |
| acc_err | output | 1 | Access to a mapped word with a rejected width |
| ev_timer | input | 1 | Timer overflow event |
| ev_busmstr | input | 1 | Bus-master activity event |
| ev_global | input | 1 | Global lock release event |
| ev_pwrbtn | input | 1 | Power button event |
| ev_slpbtn | input | 1 | Sleep button event |
| ev_rtc | input | 1 | Real-time clock alarm event |
| ev_wake | input | 1 | Wake event |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
The enable word is swept with every single-bit write pattern and an all-ones pattern, which separates the two storing bits from the fourteen that must drop. The status word is swept by latching every event and then clearing one bit position at a time, telling the clearable subset apart from the sticky timer and global bits and from unused positions. Every access width from 0 to 7 bytes is tried on both words and every address of the small window is read, distinguishing rejected widths from unmapped addresses. Enable and status combinations around the power-button and global pairs, plus events coinciding with clears and repeated power-button pulses, show that SCI tracks the level and that set beats clear.

// File: rtl/pm1_pkg.sv
package pm1_pkg;

    localparam int REG_W = 16;

    localparam int B_TMR = 0;
    localparam int B_BM  = 4;
    localparam int B_GBL = 5;
    localparam int B_PWR = 8;
    localparam int B_SLP = 9;
    localparam int B_RTC = 10;
    localparam int B_WAK = 15;

    localparam logic [REG_W-1:0] ONE = REG_W'(1);

    // status bits that any event source can latch
    localparam logic [REG_W-1:0] ST_EVT_MASK =
        (ONE << B_TMR) | (ONE << B_BM) | (ONE << B_GBL) | (ONE << B_PWR) |
        (ONE << B_SLP) | (ONE << B_RTC) | (ONE << B_WAK);

    // status bits that software may clear by writing one
    localparam logic [REG_W-1:0] ST_W1C_MASK =
        (ONE << B_BM) | (ONE << B_PWR) | (ONE << B_SLP) |
        (ONE << B_RTC) | (ONE << B_WAK);

    // enable bits that hold a written value
    localparam logic [REG_W-1:0] EN_WR_MASK = (ONE << B_GBL) | (ONE << B_PWR);

    // bit positions whose enable/status pair can raise the interrupt
    localparam logic [REG_W-1:0] SCI_PAIR_MASK =
        (ONE << B_TMR) | (ONE << B_GBL) | (ONE << B_PWR) |
        (ONE << B_SLP) | (ONE << B_RTC);

    typedef struct packed {
        logic rd_st;
        logic rd_en;
        logic wr_st;
        logic wr_en;
        logic err;
    } pm1_dec_t;

endpackage

// File: rtl/pm1_acc_dec.sv
module pm1_acc_dec
    import pm1_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(4)
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    output pm1_dec_t          dec
);
    localparam logic [ADDR_W-1:0] EN_ADDR   = BASE_ADDR + ADDR_W'(2);
    localparam logic [2:0]        WORD_SIZE = 3'd2;

    logic hit_st, hit_en, size_ok;

    always_comb begin
        hit_st    = acc_valid && (acc_addr == BASE_ADDR);
        hit_en    = acc_valid && (acc_addr == EN_ADDR);
        size_ok   = (acc_size == WORD_SIZE);
        dec.err   = (hit_st || hit_en) && !size_ok;
        dec.rd_st = hit_st && size_ok && !acc_write;
        dec.rd_en = hit_en && size_ok && !acc_write;
        dec.wr_st = hit_st && size_ok && acc_write;
        dec.wr_en = hit_en && size_ok && acc_write;
    end
endmodule

// File: rtl/pm1_status_reg.sv
module pm1_status_reg
    import pm1_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] ev_set,
    output logic [REG_W-1:0] st_d,
    output logic [REG_W-1:0] st_q
);
    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d = st_d & ~(wdata & ST_W1C_MASK);
        end
        // a new event is applied after the clear, so it wins a tie
        st_d = st_d | (ev_set & ST_EVT_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pm1_enable_reg.sv
module pm1_enable_reg
    import pm1_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] en_d,
    output logic [REG_W-1:0] en_q
);
    always_comb begin
        en_d = en_q;
        if (wr) begin
            en_d = wdata & EN_WR_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end
endmodule

// File: rtl/pm1_sci_gen.sv
module pm1_sci_gen
    import pm1_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] st_d,
    input  logic [REG_W-1:0] en_d,
    output logic             sci_q
);
    logic [REG_W-1:0] pair_hit;
    logic             sci_d;

    for (genvar i = 0; i < REG_W; i++) begin : g_pair
        if (SCI_PAIR_MASK[i]) begin : g_live
            assign pair_hit[i] = st_d[i] & en_d[i];
        end else begin : g_dead
            assign pair_hit[i] = 1'b0;
        end
    end

    always_comb begin
        sci_d = |pair_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_q <= 1'b0;
        end else begin
            sci_q <= sci_d;
        end
    end
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
    import pm1_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    input  logic [15:0]       acc_wdata,
    output logic [15:0]       acc_rdata,
    output logic              acc_err,
    input  logic              ev_timer,
    input  logic              ev_busmstr,
    input  logic              ev_global,
    input  logic              ev_pwrbtn,
    input  logic              ev_slpbtn,
    input  logic              ev_rtc,
    input  logic              ev_wake,
    output logic              sci
);
    pm1_dec_t         dec;
    logic [REG_W-1:0] ev_set;
    logic [REG_W-1:0] st_d, st_q;
    logic [REG_W-1:0] en_d, en_q;

    always_comb begin
        ev_set        = '0;
        ev_set[B_TMR] = ev_timer;
        ev_set[B_BM]  = ev_busmstr;
        ev_set[B_GBL] = ev_global;
        ev_set[B_PWR] = ev_pwrbtn;
        ev_set[B_SLP] = ev_slpbtn;
        ev_set[B_RTC] = ev_rtc;
        ev_set[B_WAK] = ev_wake;
    end

    pm1_acc_dec #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_addr (acc_addr),
        .acc_size (acc_size),
        .dec      (dec)
    );

    pm1_status_reg u_st (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (dec.wr_st),
        .wdata (acc_wdata),
        .ev_set(ev_set),
        .st_d  (st_d),
        .st_q  (st_q)
    );

    pm1_enable_reg u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (dec.wr_en),
        .wdata(acc_wdata),
        .en_d (en_d),
        .en_q (en_q)
    );

    pm1_sci_gen u_sci (
        .clk  (clk),
        .rst_n(rst_n),
        .st_d (st_d),
        .en_d (en_d),
        .sci_q(sci)
    );

    always_comb begin
        acc_err   = dec.err;
        acc_rdata = '0;
        if (dec.rd_st) begin
            acc_rdata = st_q;
        end else if (dec.rd_en) begin
            acc_rdata = en_q;
        end
    end
endmodule

// File: rtl/pm1_evt_regs_chk.sv
module pm1_evt_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [2:0]  acc_size,
    input logic        acc_err,
    input logic        ev_timer,
    input logic        ev_busmstr,
    input logic        ev_global,
    input logic        ev_pwrbtn,
    input logic        ev_slpbtn,
    input logic        ev_rtc,
    input logic        ev_wake,
    input logic [15:0] st_q,
    input logic [15:0] en_q,
    input logic        sci
);
    logic any_ev;
    always_comb begin
        any_ev = ev_timer | ev_busmstr | ev_global | ev_pwrbtn |
                 ev_slpbtn | ev_rtc | ev_wake;
    end

    // R2
    bad_size_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_valid && acc_size != 3'd2));

    // R2
    rejected_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_err && !any_ev) |=> ($stable(st_q) && $stable(en_q)));

    // R6
    enable_bits_limited_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~16'h0120) == 16'h0000);

    // R7
    sci_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci == ((st_q & en_q & 16'h0721) != 16'h0000));

    // R8
    pwr_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pwrbtn |=> st_q[8]);

    // R4
    rtc_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rtc |=> st_q[10]);

    // R5
    timer_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[0] |=> st_q[0]);

    // R5
    global_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[5] |=> st_q[5]);
endmodule

bind pm1_evt_regs pm1_evt_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_err   (acc_err),
    .ev_timer  (ev_timer),
    .ev_busmstr(ev_busmstr),
    .ev_global (ev_global),
    .ev_pwrbtn (ev_pwrbtn),
    .ev_slpbtn (ev_slpbtn),
    .ev_rtc    (ev_rtc),
    .ev_wake   (ev_wake),
    .st_q      (st_q),
    .en_q      (en_q),
    .sci       (sci)
);

// File: tb/tb_pm1_evt_regs.sv
module tb_pm1_evt_regs;
    localparam logic [3:0] BASE = 4'h4;
    localparam logic [3:0] ENA  = 4'h6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [2:0]  acc_size = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        acc_err;
    logic [6:0]  ev = '0; // {wake, rtc, slp, pwr, gbl, bm, tmr}
    logic        sci;

    int checks = 0;
    int errors = 0;
    logic [15:0] st_m = '0;
    logic [15:0] en_m = '0;

    always #2 clk = ~clk;

    pm1_evt_regs #(.ADDR_W(4), .BASE_ADDR(BASE)) dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_err(acc_err),
        .ev_timer(ev[0]), .ev_busmstr(ev[1]), .ev_global(ev[2]),
        .ev_pwrbtn(ev[3]), .ev_slpbtn(ev[4]), .ev_rtc(ev[5]), .ev_wake(ev[6]),
        .sci(sci)
    );

    function automatic logic [15:0] ev_bits(input logic [6:0] v);
        return {v[6], 4'b0, v[5], v[4], v[3], 2'b0, v[2], v[1], 3'b0, v[0]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one host access and/or event pulse lasting a single cycle
    task automatic op(input logic v, input logic w, input logic [3:0] a,
                      input logic [2:0] sz, input logic [15:0] wd, input logic [6:0] e);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = wd; ev = e;
        if (v && w && sz == 3'd2 && a == BASE) st_m = st_m & ~(wd & 16'h8710);
        if (v && w && sz == 3'd2 && a == ENA)  en_m = wd & 16'h0120;
        st_m = st_m | ev_bits(e);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; ev = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [2:0] sz,
                      output logic [15:0] d, output logic e);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
        #1;
        d = acc_rdata; e = acc_err;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic verify(input string req);
        logic [15:0] d;
        logic e;
        rd(BASE, 3'd2, d, e);
        check({req, " status"}, d, st_m);
        check({req, " status err"}, {15'b0, e}, 16'h0);
        rd(ENA, 3'd2, d, e);
        check({req, " enable"}, d, en_m);
        check({req, " sci"}, {15'b0, sci}, {15'b0, ((st_m & en_m & 16'h0721) != 0)});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        st_m = '0; en_m = '0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic e;
        do_reset();
        // R1 reset state
        verify("R1");

        // R6 single-bit enable sweep
        for (int i = 0; i < 16; i++) begin
            op(1, 1, ENA, 3'd2, 16'h1 << i, 7'h0);
            verify("R6");
        end
        op(1, 1, ENA, 3'd2, 16'hFFFF, 7'h0);
        verify("R6");

        // R2 rejected widths on both words
        op(0, 0, BASE, 3'd2, 16'h0, 7'h7F);
        for (int s = 0; s < 8; s++) begin
            if (s != 2) begin
                @(negedge clk);
                acc_valid = 1; acc_write = 1; acc_addr = ENA; acc_size = 3'(s); acc_wdata = 16'h0;
                #1 check("R2 enable write err", {15'b0, acc_err}, 16'h1);
                @(negedge clk);
                acc_addr = BASE; acc_wdata = 16'hFFFF;
                #1 check("R2 status write err", {15'b0, acc_err}, 16'h1);
                @(negedge clk);
                acc_valid = 0; acc_write = 0;
                rd(BASE, 3'(s), d, e);
                check("R2 read data", d, 16'h0);
                check("R2 read err", {15'b0, e}, 16'h1);
                verify("R2");
            end
        end

        // R3 every other address reads zero without error
        for (int a = 0; a < 16; a++) begin
            if (a != 4 && a != 6) begin
                rd(4'(a), 3'd2, d, e);
                check("R3 unmapped data", d, 16'h0);
                check("R3 unmapped err", {15'b0, e}, 16'h0);
            end
        end

        // R4 each event alone, after a full clear
        do_reset();
        for (int k = 0; k < 7; k++) begin
            op(1, 1, BASE, 3'd2, 16'hFFFF, 7'h0);
            op(0, 0, BASE, 3'd2, 16'h0, 7'(1 << k));
            verify("R4");
        end

        // R5 clear one bit position at a time
        for (int i = 0; i < 16; i++) begin
            op(0, 0, BASE, 3'd2, 16'h0, 7'h7F);
            op(1, 1, BASE, 3'd2, 16'h1 << i, 7'h0);
            verify("R5");
        end

        // R7 interrupt level over enable/status combinations
        do_reset();
        op(1, 1, ENA, 3'd2, 16'h0100, 7'h0);
        verify("R7 en only");
        op(0, 0, BASE, 3'd2, 16'h0, 7'h08);
        verify("R7 pwr pair");
        op(1, 1, BASE, 3'd2, 16'h0100, 7'h0);
        verify("R7 pwr cleared");
        op(0, 0, BASE, 3'd2, 16'h0, 7'h72);
        verify("R7 unpaired events");
        op(0, 0, BASE, 3'd2, 16'h0, 7'h08);
        op(1, 1, ENA, 3'd2, 16'h0000, 7'h0);
        verify("R7 enable dropped");
        op(1, 1, ENA, 3'd2, 16'h0020, 7'h0);
        verify("R7 gbl en no status");
        op(0, 0, BASE, 3'd2, 16'h0, 7'h04);
        verify("R7 gbl pair");

        // R8 event beats a same-cycle clear
        do_reset();
        op(1, 1, BASE, 3'd2, 16'h8710, 7'h48);
        verify("R8");
        check("R8 pwr bit", st_m & 16'h8100, 16'h8100);

        // R9 repeated power-button events
        op(1, 1, ENA, 3'd2, 16'h0100, 7'h0);
        op(0, 0, BASE, 3'd2, 16'h0, 7'h08);
        op(0, 0, BASE, 3'd2, 16'h0, 7'h08);
        verify("R9");
        @(negedge clk);
        ev = 7'h08;
        repeat (3) @(negedge clk);
        ev = 7'h00;
        verify("R9 held");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule